// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps the machine-check error record for a processor. It holds a set of error banks. Each bank has a control mask, a status word, an error address and a miscellaneous word. The block also holds one capability register, one global control register and one global status register.

Error sources send reports over a valid/ready port. A report carries a bank index, a 64-bit status word, a global status value, an address and a misc value. For each accepted report the block decides one of five outcomes:

- drop the report;
- log it;
- overwrite the bank;
- only flag overflow on the entry already held;
- escalate to a system reset request.

A logged uncorrected error raises a one-cycle machine-check interrupt. Software reads and writes every register through a simple word-addressed register port. Software clears entries by writing status words.

The register map is as follows:

- Address 0 is the capability register. Bits 7:0 hold the usable bank count. Bit 8 is the control-present flag.
- Address 1 is global control.
- Address 2 is global status. Bit 2 is the in-progress flag.
- Address 3 reads zero.
- Bank b occupies addresses 4+4b to 7+4b, in the order control, status, address, misc.

Status words use three fixed bits: valid is bit 63, overflow is bit 62 and uncorrected is bit 61.

Top module: `mce_bank_logger`

## Requirements
- R1: After reset, global control and every bank control read all ones. Global status and every bank status read zero. The capability register reads the bank-count parameter in bits 7:0 with bit 8 set (0x104 for four banks). The report port is ready.
- R2: A report is dropped with no register change and no pulse if either of these holds: its bank index is not below capability bits 7:0 (or not below the number of physical banks), or its status bit 63 is clear.
- R3: An uncorrected report (status bit 61 set) is dropped when capability bit 8 is set and global control is not all ones. With capability bit 8 clear, global control is ignored.
- R4: An uncorrected report is dropped when the target bank's control register is not all ones.
- R5: An uncorrected report is not logged if global status bit 2 is set or the machine-check enable input is low. Instead `reset_req_o` pulses one cycle after acceptance, and no bank or global register changes.
- R6: An uncorrected report that passes every check is logged in full. The bank status takes the incoming status, with bit 62 set if the bank already held a valid entry. The bank address and misc take the report's values. Global status takes the report's global status. `mc_irq_o` pulses one cycle after acceptance.
- R7: A corrected report to a bank that is empty or holds a corrected entry overwrites status, address and misc. Bit 62 is set if the old entry was valid. No pulse is raised.
- R8: A corrected report to a bank holding a valid uncorrected entry leaves that entry's status, address and misc intact except for setting status bit 62.
- R9: `rpt_ready_o` is low in any cycle with a register write, and no report is taken then. `mc_irq_o` and `reset_req_o` are high for exactly one cycle per qualifying report.
- R10: Software writes to any register through the register port read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mce_en_i | input | 1 | Machine-check enable; low makes uncorrected reports request reset |
| rpt_valid_i | input | 1 | Error report valid |
| rpt_ready_o | output | 1 | Error report accepted when high with valid |
| rpt_bank_i | input | 8 | Target bank index |
| rpt_status_i | input | 64 | Report status word |
| rpt_gstatus_i | input | 64 | Global status value to store on an uncorrected log |
| rpt_addr_i | input | 64 | Error address |
| rpt_misc_i | input | 64 | Miscellaneous error information |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| mc_irq_o | output | 1 | One-cycle machine-check interrupt |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions rely on three assumptions about the inputs:

- A report and a register write never complete in the same cycle. The ready signal enforces this.
- The reported global status is held stable while valid is high.
- The bank parameter is no larger than 255.

The stimulus drives every input on the falling clock edge. It raises the report valid and the register write together only once, on purpose, to show the report is refused. Every uncorrected-log check is preceded by software clearing the in-progress bit, so the reset-escalation path is entered only where a check expects it.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned ST_VAL    = 63;
  localparam int unsigned ST_OVF    = 62;
  localparam int unsigned ST_UC     = 61;
  localparam int unsigned GS_INPROG = 2;
  localparam int unsigned CAP_CTLP  = 8;

  localparam logic [1:0] FLD_CTL  = 2'd0;
  localparam logic [1:0] FLD_STAT = 2'd1;
  localparam logic [1:0] FLD_ADDR = 2'd2;
  localparam logic [1:0] FLD_MISC = 2'd3;

  typedef enum logic [2:0] {
    ACT_DROP,
    ACT_RESET,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_FLAG_OVF
  } act_e;
endpackage

// File: rtl/mce_decide.sv
module mce_decide
  import mce_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic [7:0]      bank_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [7:0]      cap_cnt_i,
  input  logic            cap_ctlp_i,
  input  logic [XLEN-1:0] gctl_i,
  input  logic [XLEN-1:0] bctl_i,
  input  logic [XLEN-1:0] old_status_i,
  input  logic            inprog_i,
  input  logic            mce_en_i,
  output act_e            act_o,
  output logic [XLEN-1:0] new_status_o
);
  localparam logic [8:0] NB9 = 9'(NUM_BANKS);

  logic in_range, uc, old_valid, old_uc;

  always_comb begin
    in_range     = (bank_i < cap_cnt_i) && ({1'b0, bank_i} < NB9);
    uc           = status_i[ST_UC];
    old_valid    = old_status_i[ST_VAL];
    old_uc       = old_status_i[ST_UC];
    act_o        = ACT_DROP;
    new_status_o = status_i;
    if (in_range && status_i[ST_VAL]) begin
      if (uc) begin
        if (cap_ctlp_i && (gctl_i != '1)) begin
          act_o = ACT_DROP;
        end else if (bctl_i != '1) begin
          act_o = ACT_DROP;
        end else if (inprog_i || !mce_en_i) begin
          act_o = ACT_RESET;
        end else begin
          act_o                = ACT_LOG_UC;
          new_status_o[ST_OVF] = status_i[ST_OVF] | old_valid;
        end
      end else if (!old_valid || !old_uc) begin
        act_o                = ACT_LOG_CE;
        new_status_o[ST_OVF] = status_i[ST_OVF] | old_valid;
      end else begin
        // keep the uncorrected record, only mark that something was lost
        act_o                = ACT_FLAG_OVF;
        new_status_o         = old_status_i;
        new_status_o[ST_OVF] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mce_bank.sv
module mce_bank
  import mce_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sw_we_i,
  input  logic [1:0]      sw_fld_i,
  input  logic [XLEN-1:0] sw_wdata_i,
  input  logic            log_we_i,
  input  logic            ovf_set_i,
  input  logic [XLEN-1:0] log_status_i,
  input  logic [XLEN-1:0] log_addr_i,
  input  logic [XLEN-1:0] log_misc_i,
  output logic [XLEN-1:0] ctl_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] misc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o    <= '1;
      status_o <= '0;
      addr_o   <= '0;
      misc_o   <= '0;
    end else if (sw_we_i) begin
      case (sw_fld_i)
        FLD_CTL:  ctl_o    <= sw_wdata_i;
        FLD_STAT: status_o <= sw_wdata_i;
        FLD_ADDR: addr_o   <= sw_wdata_i;
        default:  misc_o   <= sw_wdata_i;
      endcase
    end else if (log_we_i) begin
      status_o <= log_status_i;
      addr_o   <= log_addr_i;
      misc_o   <= log_misc_i;
    end else if (ovf_set_i) begin
      status_o[ST_OVF] <= 1'b1;
    end
  end

  AST_OVF_MARKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set_i && !sw_we_i) |=> (status_o[ST_OVF] && $stable(addr_o) && $stable(misc_o))); // R8

  AST_CTL_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> $stable(ctl_o)); // R10
endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
  import mce_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned REG_AW   = $clog2(4 + 4 * NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mce_en_i,
  input  logic              rpt_valid_i,
  output logic              rpt_ready_o,
  input  logic [7:0]        rpt_bank_i,
  input  logic [XLEN-1:0]   rpt_status_i,
  input  logic [XLEN-1:0]   rpt_gstatus_i,
  input  logic [XLEN-1:0]   rpt_addr_i,
  input  logic [XLEN-1:0]   rpt_misc_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [XLEN-1:0]   reg_wdata_i,
  output logic [XLEN-1:0]   reg_rdata_o,
  output logic              mc_irq_o,
  output logic              reset_req_o
);
  localparam int unsigned GRP_W = REG_AW - 2;
  localparam logic [XLEN-1:0] CAP_INIT =
    (XLEN'(1) << CAP_CTLP) | XLEN'(NUM_BANKS & 8'hff);

  logic [XLEN-1:0] cap_q, gctl_q, gstatus_q;
  logic [XLEN-1:0] bctl_a [NUM_BANKS];
  logic [XLEN-1:0] bstat_a[NUM_BANKS];
  logic [XLEN-1:0] baddr_a[NUM_BANKS];
  logic [XLEN-1:0] bmisc_a[NUM_BANKS];
  logic [XLEN-1:0] sel_bctl, sel_bstat, new_status;
  logic [GRP_W-1:0] grp;
  logic [1:0]       fld;
  logic             is_glob, accept;
  logic             irq_q, rrq_q;
  act_e             act;

  assign grp         = reg_addr_i[REG_AW-1:2];
  assign fld         = reg_addr_i[1:0];
  assign is_glob     = (grp == '0);
  assign rpt_ready_o = !reg_we_i;
  assign accept      = rpt_valid_i && rpt_ready_o;

  always_comb begin
    sel_bctl  = '1;
    sel_bstat = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rpt_bank_i == 8'(b)) begin
        sel_bctl  = bctl_a[b];
        sel_bstat = bstat_a[b];
      end
    end
  end

  mce_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .bank_i       (rpt_bank_i),
    .status_i     (rpt_status_i),
    .cap_cnt_i    (cap_q[7:0]),
    .cap_ctlp_i   (cap_q[CAP_CTLP]),
    .gctl_i       (gctl_q),
    .bctl_i       (sel_bctl),
    .old_status_i (sel_bstat),
    .inprog_i     (gstatus_q[GS_INPROG]),
    .mce_en_i     (mce_en_i),
    .act_o        (act),
    .new_status_o (new_status)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = accept && (rpt_bank_i == 8'(b));
    mce_bank u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sw_we_i      (reg_we_i && (grp == GRP_W'(b + 1))),
      .sw_fld_i     (fld),
      .sw_wdata_i   (reg_wdata_i),
      .log_we_i     (hit && (act == ACT_LOG_UC || act == ACT_LOG_CE)),
      .ovf_set_i    (hit && (act == ACT_FLAG_OVF)),
      .log_status_i (new_status),
      .log_addr_i   (rpt_addr_i),
      .log_misc_i   (rpt_misc_i),
      .ctl_o        (bctl_a[b]),
      .status_o     (bstat_a[b]),
      .addr_o       (baddr_a[b]),
      .misc_o       (bmisc_a[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= CAP_INIT;
      gctl_q    <= '1;
      gstatus_q <= '0;
      irq_q     <= 1'b0;
      rrq_q     <= 1'b0;
    end else begin
      irq_q <= accept && (act == ACT_LOG_UC);
      rrq_q <= accept && (act == ACT_RESET);
      if (reg_we_i && is_glob) begin
        case (fld)
          2'd0:    cap_q     <= reg_wdata_i;
          2'd1:    gctl_q    <= reg_wdata_i;
          2'd2:    gstatus_q <= reg_wdata_i;
          default: ;
        endcase
      end else if (accept && (act == ACT_LOG_UC)) begin
        gstatus_q <= rpt_gstatus_i;
      end
    end
  end

  assign mc_irq_o    = irq_q;
  assign reset_req_o = rrq_q;

  always_comb begin
    reg_rdata_o = '0;
    if (is_glob) begin
      case (fld)
        2'd0:    reg_rdata_o = cap_q;
        2'd1:    reg_rdata_o = gctl_q;
        2'd2:    reg_rdata_o = gstatus_q;
        default: reg_rdata_o = '0;
      endcase
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (grp == GRP_W'(b + 1)) begin
          case (fld)
            FLD_CTL:  reg_rdata_o = bctl_a[b];
            FLD_STAT: reg_rdata_o = bstat_a[b];
            FLD_ADDR: reg_rdata_o = baddr_a[b];
            default:  reg_rdata_o = bmisc_a[b];
          endcase
        end
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mc_irq_o && reset_req_o)); // R9

  AST_RESET_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $stable(gstatus_q)); // R5

  AST_IRQ_GSTATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_irq_o |-> (gstatus_q == $past(rpt_gstatus_i))); // R6

  AST_NO_TAKE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !(mc_irq_o || reset_req_o)); // R9

  AST_IRQ_IS_UC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_irq_o |-> $past(rpt_status_i[ST_UC] && rpt_status_i[ST_VAL])); // R6
endmodule

// File: tb/mce_bank_logger_tb.sv
module mce_bank_logger_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = $clog2(4 + 4 * NB);
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [7:0]  bank;
    logic [63:0] st;
    logic [63:0] gs;
    logic        irq;
    logic        rrq;
    logic [7:0]  cb;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd0, 64'h8000_0000_0000_0011, 64'h0, 1'b0, 1'b0, 8'd0, 64'h8000_0000_0000_0011}, // R7 empty
    '{8'd0, 64'h8000_0000_0000_0022, 64'h0, 1'b0, 1'b0, 8'd0, 64'hC000_0000_0000_0022}, // R7 over CE
    '{8'd1, 64'hA000_0000_0000_0033, 64'h5, 1'b1, 1'b0, 8'd1, 64'hA000_0000_0000_0033}, // R6
    '{8'd1, 64'h8000_0000_0000_0044, 64'h0, 1'b0, 1'b0, 8'd1, 64'hE000_0000_0000_0033}, // R8
    '{8'd2, 64'hA000_0000_0000_0055, 64'h0, 1'b0, 1'b1, 8'd2, 64'h0},                   // R5 in progress
    '{8'd4, 64'h8000_0000_0000_0001, 64'h0, 1'b0, 1'b0, 8'd3, 64'h0},                   // R2 range
    '{8'd2, 64'h0000_0000_0000_0066, 64'h0, 1'b0, 1'b0, 8'd2, 64'h0}                    // R2 invalid
  };

  logic clk = 1'b0, rst_n = 1'b0, mce_en = 1'b1;
  logic rpt_valid = 1'b0, rpt_ready;
  logic [7:0] rpt_bank = '0;
  logic [63:0] rpt_status = '0, rpt_gs = '0, rpt_addr = '0, rpt_misc = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mc_irq, rst_req;
  int n_chk = 0, n_fail = 0;
  logic [63:0] rd;
  logic irq_s, rrq_s;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mce_bank_logger #(.NUM_BANKS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mce_en_i(mce_en),
    .rpt_valid_i(rpt_valid), .rpt_ready_o(rpt_ready), .rpt_bank_i(rpt_bank),
    .rpt_status_i(rpt_status), .rpt_gstatus_i(rpt_gs), .rpt_addr_i(rpt_addr),
    .rpt_misc_i(rpt_misc), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mc_irq_o(mc_irq), .reset_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] badr(input int b, input int f);
    return AW'(4 + 4 * b + f);
  endfunction

  task automatic reg_wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                      input logic [63:0] ad, input logic [63:0] mi,
                      output logic irq, output logic rrq);
    @(negedge clk);
    rpt_valid = 1'b1; rpt_bank = b; rpt_status = st; rpt_gs = gs;
    rpt_addr = ad; rpt_misc = mi;
    @(negedge clk);
    rpt_valid = 1'b0;
    irq = mc_irq; rrq = rst_req;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(AW'(0), rd); chk("R1 cap", rd, 64'h104);
    reg_rd(AW'(1), rd); chk("R1 gctl", rd, ONES);
    reg_rd(AW'(2), rd); chk("R1 gstatus", rd, 64'h0);
    reg_rd(badr(0, 0), rd); chk("R1 bank0 ctl", rd, ONES);
    reg_rd(badr(3, 0), rd); chk("R1 bank3 ctl", rd, ONES);
    reg_rd(badr(2, 1), rd); chk("R1 bank2 status", rd, 64'h0);
    chk("R1 ready", 64'(rpt_ready), 64'h1);

    // vector table
    for (int i = 0; i < 7; i++) begin
      send(VECS[i].bank, VECS[i].st, VECS[i].gs, 64'h1000 + 64'(i), 64'h2000 + 64'(i),
           irq_s, rrq_s);
      chk($sformatf("vec%0d irq (R6)", i), 64'(irq_s), 64'(VECS[i].irq));
      chk($sformatf("vec%0d reset req (R5)", i), 64'(rrq_s), 64'(VECS[i].rrq));
      reg_rd(badr(int'(VECS[i].cb), 1), rd);
      chk($sformatf("vec%0d bank status", i), rd, VECS[i].exp);
      chk($sformatf("vec%0d pulse width (R9)", i), {62'b0, mc_irq, rst_req}, 64'h0);
    end
    reg_rd(AW'(2), rd); chk("R5 gstatus kept after reset req", rd, 64'h5);
    reg_rd(badr(1, 2), rd); chk("R6 bank1 addr", rd, 64'h1002);
    reg_rd(badr(1, 3), rd); chk("R8 bank1 misc kept", rd, 64'h2002);
    reg_rd(badr(0, 2), rd); chk("R7 bank0 addr overwritten", rd, 64'h1001);

    // R9 report refused during register write; clears in-progress too
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(2); reg_wdata = 64'h0;
    rpt_valid = 1'b1; rpt_bank = 8'd3; rpt_status = 64'h8000_0000_0000_00EE;
    #1 chk("R9 ready low on write", 64'(rpt_ready), 64'h0);
    @(negedge clk);
    reg_we = 1'b0; rpt_valid = 1'b0;
    reg_rd(badr(3, 1), rd); chk("R9 report not taken", rd, 64'h0);
    reg_rd(AW'(2), rd); chk("R10 gstatus write", rd, 64'h0);

    // R6 logging to empty bank, R9 single-cycle pulse
    send(8'd3, 64'hA000_0000_0000_0077, 64'h1, 64'h3300, 64'h4400, irq_s, rrq_s);
    chk("R6 irq", 64'(irq_s), 64'h1);
    @(negedge clk); chk("R9 irq one cycle", 64'(mc_irq), 64'h0);
    reg_rd(badr(3, 1), rd); chk("R6 bank3 status", rd, 64'hA000_0000_0000_0077);
    reg_rd(AW'(2), rd); chk("R6 gstatus", rd, 64'h1);

    // R3 global control gating
    reg_wr(AW'(1), 64'h0);
    send(8'd2, 64'hA000_0000_0000_0080, 64'h0, 64'h1, 64'h1, irq_s, rrq_s);
    chk("R3 dropped irq", 64'(irq_s), 64'h0);
    reg_rd(badr(2, 1), rd); chk("R3 dropped status", rd, 64'h0);
    reg_wr(AW'(0), 64'h004);
    send(8'd2, 64'hA000_0000_0000_0088, 64'h0, 64'h5500, 64'h6600, irq_s, rrq_s);
    chk("R3 ctl-present clear irq", 64'(irq_s), 64'h1);
    reg_rd(badr(2, 1), rd); chk("R3 ctl-present clear logged", rd, 64'hA000_0000_0000_0088);
    reg_wr(AW'(1), ONES);
    reg_wr(AW'(0), 64'h104);

    // R4 bank control gating
    reg_wr(badr(2, 0), 64'hFFFF_FFFF_FFFF_FFFE);
    send(8'd2, 64'hA000_0000_0000_0099, 64'h0, 64'h7, 64'h7, irq_s, rrq_s);
    chk("R4 dropped irq", 64'(irq_s), 64'h0);
    reg_rd(badr(2, 1), rd); chk("R4 entry kept", rd, 64'hA000_0000_0000_0088);
    reg_rd(badr(2, 2), rd); chk("R4 addr kept", rd, 64'h5500);
    reg_wr(badr(2, 0), ONES);

    // R5 enable off
    mce_en = 1'b0;
    send(8'd0, 64'hA000_0000_0000_00AB, 64'h0, 64'h9, 64'h9, irq_s, rrq_s);
    chk("R5 reset req", 64'(rrq_s), 64'h1);
    chk("R5 no irq", 64'(irq_s), 64'h0);
    @(negedge clk); chk("R9 reset req one cycle", 64'(rst_req), 64'h0);
    reg_rd(badr(0, 1), rd); chk("R5 bank0 unchanged", rd, 64'hC000_0000_0000_0022);
    mce_en = 1'b1;

    // R2 bank count from capability
    reg_wr(AW'(0), 64'h102);
    send(8'd2, 64'h8000_0000_0000_00AA, 64'h0, 64'h8, 64'h8, irq_s, rrq_s);
    reg_rd(badr(2, 1), rd); chk("R2 count limit", rd, 64'hA000_0000_0000_0088);
    reg_wr(AW'(0), 64'h104);

    // R10 software access
    reg_wr(badr(3, 2), 64'hDEAD_BEEF);
    reg_rd(badr(3, 2), rd); chk("R10 addr readback", rd, 64'hDEAD_BEEF);
    reg_wr(badr(3, 1), 64'h0);
    reg_rd(badr(3, 1), rd); chk("R10 status clear", rd, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule